// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the processor-facing side of a three-channel, 16-bit interval timer that sits on an 8-bit data bus. A 2-bit address picks one of the three channels or a shared command register. Writes to the command register do one of three things: set up a channel's byte format and counting mode, freeze a channel's count for a later read, or capture count and status for any group of channels at once. Writes to a channel address build that channel's initial count one byte at a time. Reads from a channel address return a status byte or a count byte, in a fixed order.

The counting itself lives in separate channel cores. Toward each core this block provides three things: the assembled count register value, a one-cycle strobe that marks a complete count, and the selected mode and BCD bits. From each core it takes back the live count, the OUT level, and a pulse that says the count register has been moved into the counter. The whole block runs on one clock with a synchronous, active-high reset.

The bus is made of plain strobes, not a stream. There is no back-pressure: every access completes in the cycle it is presented. One clock cycle with chip select and a strobe both low counts as exactly one access. A read presents its byte on `rdata` combinationally during that cycle, and any side effect of the read takes place at the closing clock edge. If both strobes are low in the same cycle, the write wins and the read is dropped.

Top module: `tmr_bus_regs`

## Requirements
- R1: After reset, every channel is unprogrammed, with control bits 0, count register 0, null count 0, no count or status latch held, and no load strobe. A read of an unprogrammed channel returns the low byte of its live count.
- R2: Writes and reads act only while `cs_n` is low. A read of address 3 returns 0x00 and changes nothing, and `rdata` is 0x00 in any cycle that is not a channel read.
- R3: A command write with bits 7:6 not equal to 11 and bits 5:4 nonzero programs the channel named by bits 7:6. Bits 5:4 set the access format, bits 3:1 the mode and bit 0 BCD. The write clears both count register bytes, sets null count, resets both byte pointers and releases any held latches. `chan_ctl` then shows {mode, BCD} for that channel.
- R4: In access format 11 the first data write fills the low byte and the second fills the high byte. Only the second write raises `ld_stb` for that channel, for one cycle starting at the clock edge that took the write, together with the full value on `cr_value`. At most one `ld_stb` bit is high in any cycle.
- R5: Access format 01 writes and reads only the low byte, and format 10 only the high byte. The unwritten byte stays 0, and every data write raises `ld_stb`.
- R6: A command with bits 5:4 equal to 00 freezes the named channel's live count. A second freeze before the frozen value has been fully read (one byte, or two in format 11) is ignored. After the final byte is read, reads follow the live count again.
- R7: A command with bits 7:6 equal to 11 is a read-back. In it, bit 5 low freezes count and bit 4 low freezes status, and bits 3, 2 and 1 select channels 2, 1 and 0. Each selected channel releases its frozen count independently.
- R8: The status byte is {OUT level, null count, last control bits 5:0}. When status and count are both held, the first read returns status and the next reads return the count. A second status capture before the status has been read is ignored.
- R9: Null count is set by a command write, by a one-byte data write, and by the second byte in format 11, but not by the first byte. It is cleared by the channel's `ce_loaded` pulse.
- R10: In format 11, the read byte pointer and the write byte pointer advance independently, so reads and writes to one channel may interleave.
- R11: Reprogramming a channel releases a frozen count, so the next reads follow the live count starting from the low byte.
- R12: Data writes to a channel that has not been programmed since reset are ignored: no strobe, and the count register stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0..2 channel, 3 command register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ld_stb | output | 3 | Per-channel complete-count strobe |
| cr_value | output | 48 | Per-channel count register, channel 0 in bits 15:0 |
| chan_ctl | output | 12 | Per-channel {mode[2:0], BCD}, channel 0 in bits 3:0 |
| live_cnt | input | 48 | Per-channel live count from the cores |
| out_lvl | input | 3 | Per-channel OUT level |
| ce_loaded | input | 3 | Per-channel pulse: count register moved into counter |

## Verification
The bench changes the live count between a freeze and its read, and issues a second freeze before reading. A design that lets the later freeze win, or that stops following the live count too early or too late, returns the wrong bytes. It places reads and writes in the same two-byte sequence and reprograms a channel while its count is frozen. This catches a design that shares one byte pointer between reads and writes, or that keeps a stale latch or pointer after reprogramming. It checks the null-count bit in status after the first and after the second byte, and after a second status capture with a changed OUT level. A design that sets null count one byte early, or overwrites a held status, shows the wrong status byte.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] cw_wr,
  output logic [NCH-1:0] lat_cmd,
  output logic [NCH-1:0] st_cmd,
  output logic [NCH-1:0] dat_wr,
  output logic [NCH-1:0] dat_rd
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic wr_act, rd_act, cmd_sel, rb;

  always_comb begin
    wr_act  = !cs_n && !wr_n;
    rd_act  = !cs_n && !rd_n && wr_n;
    cmd_sel = (addr == CMD_ADDR);
    rb      = (wdata[7:6] == 2'b11);
    for (int i = 0; i < NCH; i++) begin
      dat_wr[i]  = wr_act && !cmd_sel && (addr == 2'(i));
      dat_rd[i]  = rd_act && !cmd_sel && (addr == 2'(i));
      cw_wr[i]   = wr_act && cmd_sel && !rb && (wdata[7:6] == 2'(i)) && (wdata[5:4] != 2'b00);
      lat_cmd[i] = wr_act && cmd_sel &&
                   ((!rb && (wdata[7:6] == 2'(i)) && (wdata[5:4] == 2'b00)) ||
                    (rb && wdata[1+i] && !wdata[5]));
      st_cmd[i]  = wr_act && cmd_sel && rb && wdata[1+i] && !wdata[4];
    end
  end

  assert_cmd_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == CMD_ADDR || cs_n) |-> (dat_rd == '0));
  assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dat_rd));
endmodule

// File: rtl/tmr_bus_chan.sv
module tmr_bus_chan
  import tmr_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cw_wr,
  input  logic            lat_cmd,
  input  logic            st_cmd,
  input  logic            dat_wr,
  input  logic            dat_rd,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] live_cnt,
  input  logic            out_lvl,
  input  logic            ce_loaded,
  output logic [DW-1:0]   rd_byte,
  output logic            ld_stb,
  output logic [2*DW-1:0] cr_val,
  output logic [3:0]      mode_bcd
);
  localparam int CW = 2 * DW;

  logic [5:0]    ctl_q;
  logic          prog_q, null_cnt;
  logic [CW-1:0] cr_q, ol_q;
  logic          ol_held, st_held;
  logic [7:0]    stat_q;
  logic          wr_hi, rd_hi;
  acc_e          acc;
  logic [CW-1:0] rd_src;
  logic          pick_hi;

  assign acc      = acc_e'(ctl_q[5:4]);
  assign cr_val   = cr_q;
  assign mode_bcd = ctl_q[3:0];

  always_comb begin
    rd_src  = ol_held ? ol_q : live_cnt;
    pick_hi = (acc == ACC_HI) || (acc == ACC_WORD && rd_hi);
    if (st_held)      rd_byte = stat_q;
    else if (pick_hi) rd_byte = rd_src[CW-1:DW];
    else              rd_byte = rd_src[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0; prog_q <= 1'b0; null_cnt <= 1'b0; cr_q <= '0; ol_q <= '0;
      ol_held <= 1'b0; st_held <= 1'b0; stat_q <= '0;
      wr_hi <= 1'b0; rd_hi <= 1'b0; ld_stb <= 1'b0;
    end else begin
      ld_stb <= 1'b0;
      if (ce_loaded) null_cnt <= 1'b0;
      if (cw_wr) begin
        ctl_q <= wdata[5:0]; prog_q <= 1'b1; cr_q <= '0; null_cnt <= 1'b1;
        wr_hi <= 1'b0; rd_hi <= 1'b0; ol_held <= 1'b0; st_held <= 1'b0;
      end else if (dat_wr && prog_q) begin
        unique case (acc)
          ACC_LO: begin cr_q[DW-1:0] <= wdata; ld_stb <= 1'b1; null_cnt <= 1'b1; end
          ACC_HI: begin cr_q[CW-1:DW] <= wdata; ld_stb <= 1'b1; null_cnt <= 1'b1; end
          ACC_WORD: begin
            if (!wr_hi) begin
              cr_q[DW-1:0] <= wdata; wr_hi <= 1'b1;
            end else begin
              cr_q[CW-1:DW] <= wdata; wr_hi <= 1'b0; ld_stb <= 1'b1; null_cnt <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (lat_cmd && prog_q && !ol_held) begin
        ol_q <= live_cnt; ol_held <= 1'b1;
      end
      if (st_cmd && !st_held) begin
        stat_q <= {out_lvl, null_cnt, ctl_q}; st_held <= 1'b1;
      end
      if (dat_rd) begin
        if (st_held) st_held <= 1'b0;
        else if (acc == ACC_WORD) begin
          rd_hi <= !rd_hi;
          if (rd_hi) ol_held <= 1'b0;
        end else ol_held <= 1'b0;
      end
    end
  end

  assert_cw_clears_R3: assert property (@(posedge clk) disable iff (rst)
    cw_wr |=> (cr_val == '0) && null_cnt && !ol_held && !st_held);
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ol_held && !dat_rd && !cw_wr) |=> (ol_held && $stable(ol_q)));
  assert_status_first_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && st_held) |=> (!st_held && $stable(ol_held)));
  assert_unprog_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !prog_q |-> (!ld_stb && cr_val == '0));
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [NCH-1:0]      ld_stb,
  output logic [NCH*2*DW-1:0] cr_value,
  output logic [NCH*4-1:0]    chan_ctl,
  input  logic [NCH*2*DW-1:0] live_cnt,
  input  logic [NCH-1:0]      out_lvl,
  input  logic [NCH-1:0]      ce_loaded
);
  localparam int CW = 2 * DW;

  logic [NCH-1:0] cw_wr, lat_cmd, st_cmd, dat_wr, dat_rd;
  logic [DW-1:0]  rd_byte [NCH];

  tmr_bus_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .cw_wr(cw_wr), .lat_cmd(lat_cmd), .st_cmd(st_cmd),
    .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_bus_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .cw_wr(cw_wr[g]), .lat_cmd(lat_cmd[g]), .st_cmd(st_cmd[g]),
      .dat_wr(dat_wr[g]), .dat_rd(dat_rd[g]), .wdata(wdata),
      .live_cnt(live_cnt[g*CW +: CW]), .out_lvl(out_lvl[g]), .ce_loaded(ce_loaded[g]),
      .rd_byte(rd_byte[g]), .ld_stb(ld_stb[g]), .cr_val(cr_value[g*CW +: CW]),
      .mode_bcd(chan_ctl[g*4 +: 4])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (dat_rd[i]) rdata = rd_byte[i];
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_stb));
  assert_strobe_from_write_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_stb != '0) |-> $past(!cs_n && !wr_n && addr != 2'd3));
endmodule

// File: tb/tmr_bus_regs_tb.sv
module tmr_bus_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  ld_stb;
  logic [47:0] cr_value;
  logic [11:0] chan_ctl;
  logic [47:0] live_cnt = {16'h3333, 16'h2222, 16'h1111};
  logic [2:0]  out_lvl = '0;
  logic [2:0]  ce_loaded = '0;

  int errors = 0, checks = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];
  event       rd_ev;

  always #4 clk = ~clk;

  tmr_bus_regs u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ld_stb(ld_stb), .cr_value(cr_value),
    .chan_ctl(chan_ctl), .live_cnt(live_cnt), .out_lvl(out_lvl), .ce_loaded(ce_loaded)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic cs = 1'b0);
    @(negedge clk);
    cs_n = cs; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #2 -> rd_ev;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic ce_pulse(input int ch);
    @(negedge clk); ce_loaded[ch] = 1'b1;
    @(negedge clk); ce_loaded[ch] = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_ev);
    if (q_exp.size() == 0) chk(1'b0, "monitor: read with empty queue", rdata, 0);
    else chk(rdata === q_exp[0], q_tag[0], rdata, q_exp[0]);
    void'(q_exp.pop_front()); void'(q_tag.pop_front());
  end

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ld_stb == 0 && cr_value == 0 && chan_ctl == 0, "R1 reset outputs", {ld_stb, cr_value}, 0);
    chk(rdata == 8'h00, "R2 idle rdata", rdata, 0);
    bus_wr(2'd3, 8'hEE);
    bus_rd(2'd0, 8'h00, "R1 status after reset");
    bus_rd(2'd0, 8'h11, "R1 unprogrammed read low byte");
    // R2 chip select and command-address read
    bus_wr(2'd3, 8'h34, 1'b1);
    chk(chan_ctl == 0, "R2 write with cs high ignored", chan_ctl, 0);
    bus_rd(2'd3, 8'h00, "R2 read of command address");
    // R3 program channel 0: word format, mode 2
    bus_wr(2'd3, 8'h34);
    chk(chan_ctl[3:0] == 4'h4 && cr_value[15:0] == 0, "R3 control bits and cleared CR",
        {chan_ctl[3:0], cr_value[15:0]}, {4'h4, 16'h0});
    bus_wr(2'd3, 8'hE2);
    bus_rd(2'd0, 8'h74, "R3 R9 status null set by control word");
    // R4 / R9 two-byte write
    ce_pulse(0);
    bus_wr(2'd0, 8'h34);
    chk(ld_stb == 3'b000, "R4 no strobe after low byte", ld_stb, 0);
    bus_wr(2'd3, 8'hE2);
    bus_rd(2'd0, 8'h34, "R9 null stays clear after first byte");
    bus_wr(2'd0, 8'h12);
    chk(ld_stb == 3'b001 && cr_value[15:0] == 16'h1234, "R4 strobe and value after high byte",
        {ld_stb, cr_value[15:0]}, {3'b001, 16'h1234});
    @(negedge clk);
    chk(ld_stb == 3'b000, "R4 strobe lasts one cycle", ld_stb, 0);
    bus_wr(2'd3, 8'hE2);
    bus_rd(2'd0, 8'h74, "R9 null set by second byte");
    // R5 one-byte formats
    bus_wr(2'd3, 8'h51);
    bus_wr(2'd1, 8'hAB);
    chk(ld_stb == 3'b010 && cr_value[31:16] == 16'h00AB && chan_ctl[7:4] == 4'h1,
        "R5 low-only write", {ld_stb, cr_value[31:16]}, {3'b010, 16'h00AB});
    bus_wr(2'd3, 8'hA6);
    bus_wr(2'd2, 8'hCD);
    chk(ld_stb == 3'b100 && cr_value[47:32] == 16'hCD00, "R5 high-only write",
        {ld_stb, cr_value[47:32]}, {3'b100, 16'hCD00});
    bus_rd(2'd1, 8'h22, "R5 low-only read");
    bus_rd(2'd2, 8'h33, "R5 high-only read");
    // R6 counter latch, first wins
    live_cnt[15:0] = 16'hA1B2;
    bus_wr(2'd3, 8'h00);
    live_cnt[15:0] = 16'hC3D4;
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, 8'hB2, "R6 frozen low byte");
    bus_rd(2'd0, 8'hA1, "R6 frozen high byte (second latch ignored)");
    bus_rd(2'd0, 8'hD4, "R6 follows live low after release");
    bus_rd(2'd0, 8'hC3, "R6 follows live high after release");
    // R7 read-back count for channels 1 and 2
    live_cnt[31:16] = 16'h5566; live_cnt[47:32] = 16'h7788;
    bus_wr(2'd3, 8'hDC);
    live_cnt[31:16] = 16'h0000; live_cnt[47:32] = 16'h0000;
    bus_rd(2'd1, 8'h66, "R7 channel 1 frozen");
    bus_rd(2'd1, 8'h00, "R7 channel 1 released");
    bus_rd(2'd2, 8'h77, "R7 channel 2 frozen");
    bus_rd(2'd2, 8'h00, "R7 channel 2 released");
    // R8 status before count
    live_cnt[15:0] = 16'h1357; out_lvl[0] = 1'b1;
    bus_wr(2'd3, 8'hC2);
    live_cnt[15:0] = 16'h0000;
    bus_rd(2'd0, 8'hF4, "R8 status first");
    bus_rd(2'd0, 8'h57, "R8 count low after status");
    bus_rd(2'd0, 8'h13, "R8 count high after status");
    bus_rd(2'd0, 8'h00, "R8 live low after release");
    bus_rd(2'd0, 8'h00, "R8 live high after release");
    bus_wr(2'd3, 8'hE4);
    out_lvl[1] = 1'b1;
    bus_wr(2'd3, 8'hE4);
    bus_rd(2'd1, 8'h51, "R8 first status capture wins");
    bus_rd(2'd1, 8'h00, "R8 count follows after status read");
    // R10 interleaved pointers
    live_cnt[15:0] = 16'hBEEF;
    bus_rd(2'd0, 8'hEF, "R10 read low");
    bus_wr(2'd0, 8'h11);
    chk(ld_stb == 3'b000, "R10 no strobe after interleaved low write", ld_stb, 0);
    bus_rd(2'd0, 8'hBE, "R10 read high after write");
    bus_wr(2'd0, 8'h22);
    chk(ld_stb == 3'b001 && cr_value[15:0] == 16'h2211, "R10 write completes after read",
        {ld_stb, cr_value[15:0]}, {3'b001, 16'h2211});
    // R11 reprogram releases latch
    bus_wr(2'd3, 8'h00);
    live_cnt[15:0] = 16'h4242;
    bus_wr(2'd3, 8'h34);
    bus_rd(2'd0, 8'h42, "R11 live low after reprogram");
    bus_rd(2'd0, 8'h42, "R11 live high after reprogram");
    // R12 write to unprogrammed channel
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_wr(2'd2, 8'h99);
    chk(ld_stb == 3'b000 && cr_value == 0 && chan_ctl == 0, "R12 unprogrammed write ignored",
        {ld_stb, cr_value}, 0);
    repeat (2) @(negedge clk);
    chk(q_exp.size() == 0, "scoreboard drained", q_exp.size(), 0);
    finish_run();
  end
endmodule